// File: doc/BRIEF.md
# Converter Setup Register and Calibration Sequencer

This block is the control end of a sigma-delta converter's digital back end. It holds an 8-bit setup word that software writes and reads over a small parallel register bus. It decodes the two mode bits of that word into normal conversion or one of three calibration runs. It then asks a converter core for samples through a request/acknowledge handshake. Each request says which input the core must measure: the external input, the internally shorted input, or the internal reference scaled by the gain.

The results from the core go to three places. Zero-scale results go into a 24-bit offset coefficient. Full-scale results, minus that offset, go into a 24-bit gain coefficient. Conversion results, minus the offset, go into the data word. A data-ready flag (active low) tells software when a fresh conversion word is waiting. When a calibration ends, the mode bits clear themselves and conversions resume with no further write.

Top module: `sdc_setup_ctl`

## Requirements
- R1: After reset the setup word reads 0x28, `drdy` is 1, and the offset, gain and data words read 0.
- R2: Read address 0 returns the setup word, zero-extended. Its bits are: 7:6 mode, 5 clock select, 4:3 rate, 2 polarity, 1 buffer, 0 filter hold. Address 1 returns the offset, address 2 the gain and address 3 the data word. A write takes effect only at address 0; writes to addresses 1 to 3 change nothing.
- R3: Mode codes are 00 normal, 01 self-calibration, 10 zero-scale system calibration and 11 full-scale system calibration. `smp_src` encodes 0 for external input, 1 for internal shorted input and 2 for internal reference. Normal mode and both system calibrations request source 0.
- R4: Self-calibration is one command with two steps. It first requests source 1 and stores that result as the offset. It then requests source 2 and stores that result minus the offset as the gain, modulo 2^24.
- R5: Zero-scale system calibration takes a single sample and stores it as the offset, leaving the gain unchanged. Full-scale system calibration takes a single sample and stores that sample minus the offset as the gain.
- R6: When a calibration completes, the mode bits read back as 00 with no write, and conversion requests resume.
- R7: `drdy` goes to 1 when a calibration is started. It stays at 1 through the whole calibration and until the first conversion word after it has been captured.
- R8: In normal mode, an accepted sample is stored as sample minus offset, and `drdy` goes to 0. A read of address 3 with `bus_rd` sets `drdy` back to 1.
- R9: While filter hold (bit 0) is 1 in normal mode, no conversion request is made.
- R10: A setup write during a calibration aborts it and loads the new word. If the new mode is 00, `drdy` stays at 1 until the next conversion. An acknowledge arriving in the same cycle as a setup write is discarded.
- R11: A request stays asserted, with a stable source, until it is acknowledged or a setup write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (only address 3 has a side effect) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| cfg_out | output | 8 | Current setup word for the converter core |
| drdy | output | 1 | Data-ready, low when a fresh word is waiting |
| smp_req | output | 1 | Sample request to the core |
| smp_src | output | 2 | Input the core must measure |
| smp_ack | input | 1 | One-cycle acknowledge carrying `smp_val` |
| smp_val | input | DATA_W | Sample value from the core |

## Verification
The bench builds the block with its default parameters: a 24-bit data path and a reset word of 0x28. With these, the wrap-around of the offset subtraction can be reached with random 24-bit samples. Random setup writes are used, with the filter-hold bit kept mostly clear, so that every mode is entered from every other phase. This brings into reach aborts in the middle of self-calibration, a write colliding with an acknowledge, and data-ready read clears racing a new word.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    PH_CONV = 2'd0,
    PH_ZERO = 2'd1,
    PH_FULL = 2'd2
  } phase_t;

  localparam logic [1:0] MODE_NORM = 2'd0;
  localparam logic [1:0] MODE_SELF = 2'd1;
  localparam logic [1:0] MODE_SZS  = 2'd2;
  localparam logic [1:0] MODE_SFS  = 2'd3;

  localparam logic [1:0] SRC_EXT     = 2'd0;
  localparam logic [1:0] SRC_INT_ZS  = 2'd1;
  localparam logic [1:0] SRC_INT_REF = 2'd2;

  localparam logic [1:0] ADR_SETUP = 2'd0;
  localparam logic [1:0] ADR_OFS   = 2'd1;
  localparam logic [1:0] ADR_GAIN  = 2'd2;
  localparam logic [1:0] ADR_DATA  = 2'd3;

  localparam int CFG_W    = 8;
  localparam int MODE_HI  = 7;
  localparam int MODE_LO  = 6;
  localparam int HOLD_BIT = 0;
endpackage

// File: rtl/sdc_setup_reg.sv
module sdc_setup_reg
  import sdc_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VAL = 8'h28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_setup,
  input  logic [CFG_W-1:0] wdata,
  input  logic             cal_done,
  output logic [CFG_W-1:0] cfg_q
);
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_en;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (wr_setup) begin
      cfg_d  = wdata;
      cfg_en = 1'b1;
    end else if (cal_done) begin
      cfg_d[MODE_HI:MODE_LO] = MODE_NORM;
      cfg_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= RST_VAL;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // R2: the low six bits change only through a write
  a_r2_low_bits_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_setup |=> $stable(cfg_q[MODE_LO-1:0]));
endmodule

// File: rtl/sdc_cal_fsm.sv
module sdc_cal_fsm
  import sdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_setup,
  input  logic [1:0] new_mode,
  input  logic [1:0] cur_mode,
  input  logic       hold,
  input  logic       ack,
  output phase_t     phase,
  output logic       req,
  output logic [1:0] src,
  output logic       zero_cap,
  output logic       full_cap,
  output logic       conv_cap,
  output logic       cal_done,
  output logic       busy_set
);
  phase_t phase_d;
  logic   fire;

  always_comb begin
    req = (phase != PH_CONV) || !hold;
    unique case (phase)
      PH_ZERO: src = (cur_mode == MODE_SELF) ? SRC_INT_ZS  : SRC_EXT;
      PH_FULL: src = (cur_mode == MODE_SELF) ? SRC_INT_REF : SRC_EXT;
      default: src = SRC_EXT;
    endcase
  end

  assign fire     = req && ack && !wr_setup;
  assign zero_cap = fire && (phase == PH_ZERO);
  assign full_cap = fire && (phase == PH_FULL);
  assign conv_cap = fire && (phase == PH_CONV);
  assign cal_done = full_cap || (zero_cap && (cur_mode != MODE_SELF));
  assign busy_set = wr_setup && ((new_mode != MODE_NORM) || (phase != PH_CONV));

  always_comb begin
    phase_d = phase;
    if (wr_setup) begin
      unique case (new_mode)
        MODE_NORM: phase_d = PH_CONV;
        MODE_SFS:  phase_d = PH_FULL;
        default:   phase_d = PH_ZERO;
      endcase
    end else if (zero_cap) begin
      phase_d = (cur_mode == MODE_SELF) ? PH_FULL : PH_CONV;
    end else if (full_cap) begin
      phase_d = PH_CONV;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_CONV;
    else        phase <= phase_d;
  end

  // R11: an outstanding request holds with a steady source
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && !wr_setup) |=> (req && $stable(src)));
  // R4: a self-calibration zero step is followed by the reference step
  a_r4_self_order: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_cap && cur_mode == MODE_SELF) |=> (phase == PH_FULL && src == SRC_INT_REF));
  // R3: at most one capture per cycle
  a_r3_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({zero_cap, full_cap, conv_cap}));
endmodule

// File: rtl/sdc_coef_store.sv
module sdc_coef_store #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_cap,
  input  logic              full_cap,
  input  logic              conv_cap,
  input  logic              busy_set,
  input  logic              rd_data,
  input  logic [DATA_W-1:0] smp_val,
  output logic [DATA_W-1:0] offset_q,
  output logic [DATA_W-1:0] gain_q,
  output logic [DATA_W-1:0] data_q,
  output logic              drdy_q
);
  logic [DATA_W-1:0] diff;
  logic              drdy_d;

  assign diff = smp_val - offset_q;

  always_comb begin
    drdy_d = drdy_q;
    if (busy_set)      drdy_d = 1'b1;
    else if (conv_cap) drdy_d = 1'b0;
    else if (rd_data)  drdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        offset_q <= '0;
    else if (zero_cap) offset_q <= smp_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gain_q <= '0;
    else if (full_cap) gain_q <= diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (conv_cap) data_q <= diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drdy_q <= 1'b1;
    else        drdy_q <= drdy_d;
  end

  // R5: the offset moves only on a zero-scale capture
  a_r5_offset_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_cap |=> $stable(offset_q));
endmodule

// File: rtl/sdc_setup_ctl.sv
module sdc_setup_ctl
  import sdc_pkg::*;
#(
  parameter int               DATA_W  = 24,
  parameter logic [CFG_W-1:0] CFG_RST = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [CFG_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CFG_W-1:0]  cfg_out,
  output logic              drdy,
  output logic              smp_req,
  output logic [1:0]        smp_src,
  input  logic              smp_ack,
  input  logic [DATA_W-1:0] smp_val
);
  localparam int PAD_W = DATA_W - CFG_W;

  logic              wr_setup, rd_data;
  logic [CFG_W-1:0]  cfg_q;
  phase_t            phase;
  logic              zero_cap, full_cap, conv_cap, cal_done, busy_set;
  logic [DATA_W-1:0] offset_q, gain_q, data_q;

  assign wr_setup = bus_wr && (bus_addr == ADR_SETUP);
  assign rd_data  = bus_rd && (bus_addr == ADR_DATA);

  sdc_setup_reg #(.RST_VAL(CFG_RST)) u_setup (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_setup (wr_setup),
    .wdata    (bus_wdata),
    .cal_done (cal_done),
    .cfg_q    (cfg_q)
  );

  sdc_cal_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_setup (wr_setup),
    .new_mode (bus_wdata[MODE_HI:MODE_LO]),
    .cur_mode (cfg_q[MODE_HI:MODE_LO]),
    .hold     (cfg_q[HOLD_BIT]),
    .ack      (smp_ack),
    .phase    (phase),
    .req      (smp_req),
    .src      (smp_src),
    .zero_cap (zero_cap),
    .full_cap (full_cap),
    .conv_cap (conv_cap),
    .cal_done (cal_done),
    .busy_set (busy_set)
  );

  sdc_coef_store #(.DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .zero_cap (zero_cap),
    .full_cap (full_cap),
    .conv_cap (conv_cap),
    .busy_set (busy_set),
    .rd_data  (rd_data),
    .smp_val  (smp_val),
    .offset_q (offset_q),
    .gain_q   (gain_q),
    .data_q   (data_q),
    .drdy_q   (drdy)
  );

  always_comb begin
    unique case (bus_addr)
      ADR_SETUP: bus_rdata = {{PAD_W{1'b0}}, cfg_q};
      ADR_OFS:   bus_rdata = offset_q;
      ADR_GAIN:  bus_rdata = gain_q;
      default:   bus_rdata = data_q;
    endcase
  end

  assign cfg_out = cfg_q;

  // R6: a finished calibration leaves the mode field at normal
  a_r6_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !wr_setup) |=> (cfg_q[MODE_HI:MODE_LO] == MODE_NORM && phase == PH_CONV));
  // R7: data-ready stays high throughout any calibration
  a_r7_busy_drdy: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_CONV) |-> drdy);
  // R8: a captured conversion word lowers data-ready
  a_r8_word_ready: assert property (@(posedge clk) disable iff (!rst_n)
    conv_cap |=> !drdy);
  // R9: filter hold blocks conversion requests
  a_r9_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && cfg_q[HOLD_BIT]) |-> !smp_req);
  // R3: conversions always measure the external input
  a_r3_conv_external: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && smp_req) |-> (smp_src == SRC_EXT));
endmodule

// File: tb/sdc_setup_ctl_bench.sv
`timescale 1ns/1ps
module sdc_setup_ctl_bench;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]   bus_addr = 2'd0;
  logic [7:0]   bus_wdata = 8'd0;
  logic [W-1:0] bus_rdata;
  logic [7:0]   cfg_out;
  logic         drdy, smp_req, smp_ack = 1'b0;
  logic [1:0]   smp_src;
  logic [W-1:0] smp_val = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // independent model state
  logic [7:0]   m_cfg;
  int           m_ph;  // 0 conversion, 1 zero step, 2 full step
  logic [W-1:0] m_off, m_gain, m_data;
  logic         m_drdy;

  always #2.5 clk = ~clk;

  sdc_setup_ctl u_sdc_setup_ctl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_out(cfg_out), .drdy(drdy), .smp_req(smp_req), .smp_src(smp_src),
    .smp_ack(smp_ack), .smp_val(smp_val)
  );

  function automatic logic exp_req();
    return (m_ph != 0) || !m_cfg[0];
  endfunction

  function automatic logic [1:0] exp_src();
    if (m_ph == 1) return (m_cfg[7:6] == 2'd1) ? 2'd1 : 2'd0;
    if (m_ph == 2) return (m_cfg[7:6] == 2'd1) ? 2'd2 : 2'd0;
    return 2'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic [W-1:0] e [4];
    e[0] = {16'd0, m_cfg}; e[1] = m_off; e[2] = m_gain; e[3] = m_data;
    for (int a = 0; a < 4; a++) begin
      bus_addr = a[1:0];
      #0.1;
      check(bus_rdata === e[a], $sformatf("%s R2 addr%0d", tag, a), bus_rdata, e[a]);
    end
    check(drdy === m_drdy, {tag, " R7/R8 drdy"}, {23'd0, drdy}, {23'd0, m_drdy});
    check(smp_req === exp_req(), {tag, " R9/R11 req"}, {23'd0, smp_req}, {23'd0, exp_req()});
    if (exp_req())
      check(smp_src === exp_src(), {tag, " R3 src"}, {22'd0, smp_src}, {22'd0, exp_src()});
  endtask

  task automatic m_write(input logic [7:0] w);
    logic [1:0] md = w[7:6];
    if (md != 2'd0 || m_ph != 0) m_drdy = 1'b1;
    m_cfg = w;
    m_ph  = (md == 2'd0) ? 0 : (md == 2'd3) ? 2 : 1;
  endtask

  task automatic m_ack(input logic [W-1:0] v);
    case (m_ph)
      0: begin m_data = v - m_off; m_drdy = 1'b0; end
      1: begin
        m_off = v;
        if (m_cfg[7:6] == 2'd1) m_ph = 2;
        else begin m_ph = 0; m_cfg[7:6] = 2'd0; end
      end
      default: begin m_gain = v - m_off; m_ph = 0; m_cfg[7:6] = 2'd0; end
    endcase
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] w, input string tag);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 2'd0) m_write(w);
    chk_all(tag);
  endtask

  task automatic do_ack(input logic [W-1:0] v, input string tag);
    @(negedge clk);
    if (exp_req()) begin
      smp_ack = 1'b1; smp_val = v;
      @(negedge clk);
      smp_ack = 1'b0;
      m_ack(v);
    end
    chk_all(tag);
  endtask

  task automatic do_wr_ack(input logic [7:0] w, input logic [W-1:0] v, input string tag);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = w;
    smp_ack = 1'b1; smp_val = v;
    @(negedge clk);
    bus_wr = 1'b0; smp_ack = 1'b0;
    m_write(w);
    chk_all(tag);
  endtask

  task automatic do_read(input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 2'd3;
    @(negedge clk);
    bus_rd = 1'b0;
    m_drdy = 1'b1;
    chk_all(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_cfg = 8'h28; m_ph = 0; m_off = '0; m_gain = '0; m_data = '0; m_drdy = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_all("R1 reset");

    // normal conversion with zero offset, then a read clearing drdy (R8)
    do_ack(24'h000123, "R8 conv");
    do_read("R8 read");
    // self-calibration, two steps (R4, R6, R7)
    do_write(2'd0, 8'h68, "R7 self start");
    @(negedge clk); chk_all("R11 held");
    do_ack(24'h000100, "R4 zero step");
    do_ack(24'h000050, "R4 ref step wrap");
    do_ack(24'h000180, "R6 conv after cal");
    // system zero and full (R5)
    do_write(2'd0, 8'h80, "R5 sys zero start");
    do_ack(24'h000010, "R5 sys zero");
    do_write(2'd0, 8'hC4, "R5 sys full start");
    do_ack(24'h800010, "R5 sys full");
    // abort during self-calibration (R10)
    do_write(2'd0, 8'h40, "R10 start");
    do_ack(24'h000020, "R10 first step");
    do_write(2'd0, 8'h28, "R10 abort");
    do_wr_ack(8'h28, 24'h00ABCD, "R10 collide");
    // writes elsewhere ignored (R2)
    do_write(2'd1, 8'hFF, "R2 ofs write");
    do_write(2'd3, 8'hFF, "R2 data write");
    // filter hold (R9)
    do_write(2'd0, 8'h29, "R9 hold");
    do_ack(24'h000777, "R9 no req");
    do_write(2'd0, 8'h28, "R9 release");

    for (int i = 0; i < 500; i++) begin
      int op = $urandom % 8;
      logic [7:0] w = 8'($urandom);
      logic [W-1:0] v = W'($urandom);
      if ($urandom % 4 != 0) w[0] = 1'b0;
      case (op)
        0:       do_write(2'd0, w, "R3 rnd write");
        1:       do_read("R8 rnd read");
        2:       do_wr_ack(w, v, "R10 rnd collide");
        3:       do_write(2'($urandom), w, "R2 rnd addr write");
        default: do_ack(v, "R4 R5 rnd ack");
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule